// File: doc/BRIEF.md
# Mode-Programmable Bus Buffer Control

This block drives the enable pins of the external buffers that sit between two interleaved memory banks and a processor with separate instruction and data buses. An access sequencer tells it, once per clock, whether a transfer phase is in progress, which bank is active, which bank comes next, whether the access is a read or a write, and whether it is an instruction or a data access. From these the block produces six active-low pins.

Two pins are always the write-data latch enables, one per bank. The other four pins are remapped by a two-bit mode input into one of four buffer schemes:
- per-bank transmit enables;
- per-bank chip enables for transceivers that have a direction pin plus an enable;
- shared transmit enables plus a bank indicator;
- a shared chip enable plus a bank indicator.

The sequencer inputs are registered, so every pin follows the inputs sampled at the preceding rising clock edge. The mode input acts combinationally on the pin mapping and is meant to be held static.

Top module: `bus_buffer_ctl`

## Requirements
- R1: While `rstN` is low, `wrLatchN` is 2'b11 and every enable on `ctlPin` is high. The bank indicator (`ctlPin[1]` in modes 2'b10 and 2'b11) is low.
- R2: In mode 2'b00, the following pins go low, and all others are high:
  - `ctlPin[0]` for a data read from bank A;
  - `ctlPin[1]` for a data read from bank B;
  - `ctlPin[2]` for an instruction read from bank A;
  - `ctlPin[3]` for an instruction read from bank B.
- R3: In mode 2'b01, `ctlPin[0]` goes low for a data access to bank A and `ctlPin[1]` for a data access to bank B, for both reads and writes. `ctlPin[3:2]` behave as in R2.
- R4: In mode 2'b10:
  - `ctlPin[0]` goes low for a data read from either bank.
  - `ctlPin[1]` carries the registered next-bank value (1 = bank B).
  - `ctlPin[2]` and `ctlPin[3]` both go low for an instruction read from either bank.
- R5: In mode 2'b11, `ctlPin[0]` goes low for a data read or write to either bank. `ctlPin[3:1]` behave as in R4.
- R6: In every mode, `wrLatchN[0]` goes low for a data write to bank A and `wrLatchN[1]` for a data write to bank B. At most one of the two is low at a time.
- R7: An instruction access marked as a write asserts no enable and no latch enable in any mode.
- R8: When `xferOn` was low at the previous edge, all enables and latch enables are high in every mode.
- R9: Pins reflect the sequencer inputs sampled at the preceding rising edge of `clk`. A change of `mode` remaps the pins without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Buffer scheme selector |
| xferOn | input | 1 | Transfer phase active |
| xferRead | input | 1 | 1 = read toward processor, 0 = write to memory |
| xferInstr | input | 1 | 1 = instruction access, 0 = data access |
| activeBank | input | 1 | Bank being accessed (0 = A, 1 = B) |
| nextBank | input | 1 | Bank to be selected next (0 = A, 1 = B) |
| ctlPin | output | 4 | Multipurpose buffer controls, bit 0 is the first pin |
| wrLatchN | output | 2 | Write-data latch enables, bit 0 = bank A, active low |

## Verification
Under each of the four modes, every combination of transfer-on, read/write, instruction/data, active bank and next bank is applied in turn. Comparing pins across modes separates per-bank from shared enables. Comparing reads with writes separates transmit enables from chip enables, and comparing instruction writes with data writes shows that only data writes open the latches. Varying the next bank independently of the active bank shows that the indicator follows the former. A mode change in the middle of a transfer and an idle phase between transfers show the immediate remapping and the return of all enables to high.

// File: rtl/bus_buffer_pkg.sv
package bus_buffer_pkg;
  localparam int BANKS = 2;
  localparam int MODE_W = 2;
  localparam int PINS = 4;

  // mode encodings
  localparam logic [MODE_W-1:0] M_TX_PER_BANK = 2'b00;
  localparam logic [MODE_W-1:0] M_CE_PER_BANK = 2'b01;
  localparam logic [MODE_W-1:0] M_TX_SHARED   = 2'b10;
  localparam logic [MODE_W-1:0] M_CE_SHARED   = 2'b11;

  // registered strobes, active high internally
  typedef struct packed {
    logic [BANKS-1:0] dTx;
    logic [BANKS-1:0] dCe;
    logic [BANKS-1:0] iTx;
    logic [BANKS-1:0] latch;
    logic             nextB;
  } strobe_t;
endpackage

// File: rtl/bus_buffer_seq.sv
module bus_buffer_seq
  import bus_buffer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    xferOn,
  input  logic    xferRead,
  input  logic    xferInstr,
  input  logic    activeBank,
  input  logic    nextBank,
  output strobe_t stb
);
  logic [BANKS-1:0] dTxNxt, dCeNxt, iTxNxt, latchNxt;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit         = xferOn && (activeBank == 1'(b));
    assign dTxNxt[b]   = hit && !xferInstr && xferRead;
    assign dCeNxt[b]   = hit && !xferInstr;
    assign iTxNxt[b]   = hit && xferInstr && xferRead;
    assign latchNxt[b] = hit && !xferInstr && !xferRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb <= '0;
    end else begin
      stb.dTx   <= dTxNxt;
      stb.dCe   <= dCeNxt;
      stb.iTx   <= iTxNxt;
      stb.latch <= latchNxt;
      stb.nextB <= nextBank;
    end
  end
endmodule

// File: rtl/bus_buffer_map.sv
module bus_buffer_map
  import bus_buffer_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  strobe_t           stb,
  output logic [PINS-1:0]   ctlPin,
  output logic [BANKS-1:0]  wrLatchN
);
  logic anyDTx, anyDCe, anyITx;

  assign anyDTx = |stb.dTx;
  assign anyDCe = |stb.dCe;
  assign anyITx = |stb.iTx;

  always_comb begin
    unique case (mode)
      M_TX_PER_BANK: ctlPin = ~{stb.iTx[1], stb.iTx[0], stb.dTx[1], stb.dTx[0]};
      M_CE_PER_BANK: ctlPin = ~{stb.iTx[1], stb.iTx[0], stb.dCe[1], stb.dCe[0]};
      M_TX_SHARED:   ctlPin = {~anyITx, ~anyITx, stb.nextB, ~anyDTx};
      default:       ctlPin = {~anyITx, ~anyITx, stb.nextB, ~anyDCe};
    endcase
  end

  assign wrLatchN = ~stb.latch;
endmodule

// File: rtl/bus_buffer_ctl.sv
module bus_buffer_ctl
  import bus_buffer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] mode,
  input  logic              xferOn,
  input  logic              xferRead,
  input  logic              xferInstr,
  input  logic              activeBank,
  input  logic              nextBank,
  output logic [PINS-1:0]   ctlPin,
  output logic [BANKS-1:0]  wrLatchN
);
  strobe_t stb;

  bus_buffer_seq u_seq (
    .clk(clk), .rstN(rstN), .xferOn(xferOn), .xferRead(xferRead),
    .xferInstr(xferInstr), .activeBank(activeBank), .nextBank(nextBank),
    .stb(stb)
  );

  bus_buffer_map u_map (
    .mode(mode), .stb(stb), .ctlPin(ctlPin), .wrLatchN(wrLatchN)
  );
endmodule

// File: rtl/bus_buffer_chk.sv
module bus_buffer_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       xferOn,
  input logic       xferRead,
  input logic       xferInstr,
  input logic       activeBank,
  input logic       nextBank,
  input logic [3:0] ctlPin,
  input logic [1:0] wrLatchN
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2: bank A data transmit enable only after a data read of bank A
  p_tx_a_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && mode == 2'b00 && !ctlPin[0]) |->
      $past(xferOn && xferRead && !xferInstr && !activeBank));

  // R6: the two latch enables never both low
  p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~wrLatchN));

  // R6: bank B latch enable only after a data write to bank B
  p_latch_b_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !wrLatchN[1]) |->
      $past(xferOn && !xferRead && !xferInstr && activeBank));

  // R4: indicator tracks the next bank sampled one edge earlier
  p_indicator_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && mode[1]) |-> (ctlPin[1] == $past(nextBank)));

  // R8: nothing enabled after an idle edge
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(xferOn)) |->
      (wrLatchN == 2'b11 && ctlPin[0] && ctlPin[2] && ctlPin[3]
       && (mode[1] || ctlPin[1])));
endmodule

bind bus_buffer_ctl bus_buffer_chk u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .xferOn(xferOn), .xferRead(xferRead),
  .xferInstr(xferInstr), .activeBank(activeBank), .nextBank(nextBank),
  .ctlPin(ctlPin), .wrLatchN(wrLatchN)
);

// File: tb/test_bus_buffer_ctl.sv
`timescale 1ns/1ps
module test_bus_buffer_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       xferOn = 1'b0, xferRead = 1'b0, xferInstr = 1'b0;
  logic       activeBank = 1'b0, nextBank = 1'b0;
  logic [3:0] ctlPin;
  logic [1:0] wrLatchN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bus_buffer_ctl i_bus_buffer_ctl (
    .clk(clk), .rstN(rstN), .mode(mode), .xferOn(xferOn), .xferRead(xferRead),
    .xferInstr(xferInstr), .activeBank(activeBank), .nextBank(nextBank),
    .ctlPin(ctlPin), .wrLatchN(wrLatchN)
  );

  // reference model: what was seen at the last rising edge (R9)
  int seen[5];  // on, read, instr, bank, next
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (seen[i]) seen[i] = 0;
    end else begin
      seen[0] = int'(xferOn);   seen[1] = int'(xferRead);
      seen[2] = int'(xferInstr); seen[3] = int'(activeBank);
      seen[4] = int'(nextBank);
    end
  end

  function automatic logic [5:0] model(input logic [1:0] m);
    bit dataRd[2], dataAny[2], instRd[2], dataWr[2];
    logic [3:0] pins;
    for (int b = 0; b < 2; b++) begin
      bit here   = (seen[0] == 1) && (seen[3] == b);
      bit isData = (seen[2] == 0);
      dataRd[b]  = here && isData && seen[1] == 1;
      dataWr[b]  = here && isData && seen[1] == 0;
      dataAny[b] = dataRd[b] || dataWr[b];
      instRd[b]  = here && !isData && seen[1] == 1;  // R7: instr write gives nothing
    end
    case (m)
      2'd0: pins = {!instRd[1], !instRd[0], !dataRd[1], !dataRd[0]};
      2'd1: pins = {!instRd[1], !instRd[0], !dataAny[1], !dataAny[0]};
      2'd2: pins = {!(instRd[0] || instRd[1]), !(instRd[0] || instRd[1]),
                    seen[4] == 1, !(dataRd[0] || dataRd[1])};
      default: pins = {!(instRd[0] || instRd[1]), !(instRd[0] || instRd[1]),
                       seen[4] == 1, !(dataAny[0] || dataAny[1])};
    endcase
    return {!dataWr[1], !dataWr[0], pins};
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [5:0] want;
      string tag;
      want = model(mode);
      if (!rstN) tag = "R1";
      else if (seen[0] == 0) tag = "R8";
      else if (seen[2] == 1 && seen[1] == 0) tag = "R7";
      else case (mode)
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = "R5";
      endcase
      nChecks++;
      if (ctlPin !== want[3:0]) begin
        nFails++;
        $display("FAIL %s mode=%0d ctlPin actual=%b expected=%b", tag, mode, ctlPin, want[3:0]);
      end
      nChecks++;
      if (wrLatchN !== want[5:4]) begin
        nFails++;
        $display("FAIL R6 (%s) wrLatchN actual=%b expected=%b", tag, wrLatchN, want[5:4]);
      end
    end
  end

  task automatic drive(input bit on, input bit rd, input bit ins, input bit ab, input bit nb);
    @(posedge clk); #1;
    xferOn = on; xferRead = rd; xferInstr = ins; activeBank = ab; nextBank = nb;
  endtask

  initial begin
    // R1: reset state under every mode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      xferOn = 1'b1; xferRead = 1'b0;
      @(negedge clk); @(posedge clk); #1;
    end
    rstN = 1'b1;
    // R2..R7, R9: every input combination under every mode
    for (int m = 0; m < 4; m++) begin
      @(posedge clk); #1; mode = 2'(m);
      for (int v = 0; v < 32; v++)
        drive(v[4], v[3], v[2], v[1], v[0]);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);  // R8: idle gap
    end
    // R9: mode change between edges remaps at once
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #1; mode = 2'b00;
    @(negedge clk); #0.5 mode = 2'b10;
    @(posedge clk); #1; mode = 2'b01;
    // R6: back-to-back writes alternating banks
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);  // R7
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired (R9) actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule